// File: doc/BRIEF.md
# MDIO Management Master

This block issues read and write transactions to an external PHY over the two-wire management link. That link is a master-generated clock plus one shared, bidirectional data line. The host presents a PHY address, a register address, a direction flag and write data, then pulses `start`. The block derives the management clock from the system clock and shifts out the whole frame. It releases the data line at the points where the PHY owns it. When the frame ends, it reports completion.

On a read, the master stops driving at the turnaround field. It checks that the PHY pulls the line low in the second turnaround bit, then collects sixteen data bits. The result and a no-response flag appear together with the one-cycle `done` pulse and stay there until the next transaction starts.

The data line is split into an output value `mdio_o`, an output enable `mdio_oe` and a sampled input `mdio_i`. An I/O cell at the chip edge joins them into one pad.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc`, `mdio_oe`, `busy` and `done` are all low.
- R2: While a frame is in progress, `mdc` has a period of 2·HALF_DIV system clocks, with HALF_DIV clocks high and HALF_DIV clocks low, and it starts low. When idle, `mdc` stays low.
- R3: Every frame opens with 32 driven ones, followed by the start pattern 0 then 1.
- R4: The two op bits are 1,0 for a read and 0,1 for a write. They are followed by the 5-bit PHY address and then the 5-bit register address, each sent most significant bit first.
- R5: On a write, the master drives every bit of the frame. The turnaround bits are 1 then 0, and the 16 data bits follow, most significant bit first.
- R6: On a read, `mdio_oe` is high for the first 46 bits (preamble through register address) and low from the first turnaround bit to the end of the frame.
- R7: On a read, `mdio_i` is sampled at the rising `mdc` edge of each of the last 16 bits. The first sampled bit is the most significant. The result appears on `rd_data` in the same cycle that `done` rises and is held until the next read completes.
- R8: On a read, `no_resp` is set together with `done` if `mdio_i` was 1 at the rising edge of the second turnaround bit, and is 0 otherwise. It is cleared when a new transaction is accepted.
- R9: `mdio_o` changes only in the cycle where `mdc` falls, or when a transaction is accepted.
- R10: At the falling `mdc` edge that ends the 64th bit, `done` pulses high for exactly one cycle, `busy` drops and the line is released.
- R11: A `start` pulse while `busy` is high is ignored. The frame in flight keeps its original fields and no second transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| rd_req | input | 1 | 1 = read transaction, 0 = write |
| phy_addr | input | PHY_AW | Target PHY address |
| reg_addr | input | REG_AW | Target register address |
| wr_data | input | DATA_W | Data for a write |
| mdio_i | input | 1 | Sampled level of the data pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto the data pad |
| mdio_oe | output | 1 | Pad drive enable, 0 = high impedance |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last read result |
| no_resp | output | 1 | PHY did not pull turnaround low |

## Verification
The assertions take for granted that `mdio_i` is settled around each rising `mdc` edge, since the PHY changes it only after a falling edge. The bench keeps to this by updating its PHY model one step after each observed falling `mdc` edge, with half a management period of margin. The assertions place no constraint on `start` or the address inputs during a frame. The bench exercises this by pulsing `start` with a different address in the middle of a write.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;
    localparam logic [1:0] SOF_PAT  = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] TA_DRIVE = 2'b10;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] WRAP = CNT_W'(HALF_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t gen_d, gen_q;
    logic edge_now;

    assign edge_now = run && (gen_q.cnt == WRAP);
    assign rise     = edge_now && !gen_q.mdc;
    assign fall     = edge_now && gen_q.mdc;
    assign mdc      = gen_q.mdc;

    always_comb begin
        gen_d = gen_q;
        if (!run) begin
            gen_d = '0;
        end else if (edge_now) begin
            gen_d.cnt = '0;
            gen_d.mdc = !gen_q.mdc;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    // R2: the clock level holds between divider wraps
    a_r2_mdc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        run && (gen_q.cnt != WRAP) |=> $stable(mdc));
    // R2: idle clock is parked low
    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_master_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int PHY_AW  = 5,
    parameter int REG_AW  = 5,
    parameter int DATA_W  = 16
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         start,
    input  logic                                         rd_req,
    input  logic [PHY_AW-1:0]                            phy_addr,
    input  logic [REG_AW-1:0]                            reg_addr,
    input  logic [DATA_W-1:0]                            wr_data,
    input  logic                                         fall,
    output logic                                         busy,
    output logic                                         rd_mode,
    output logic [$clog2(PRE_LEN+6+PHY_AW+REG_AW+DATA_W)-1:0] bit_idx,
    output logic                                         accept,
    output logic                                         finish,
    output logic                                         mdio_o,
    output logic                                         mdio_oe,
    output logic                                         done
);
    localparam int TA_POS    = PRE_LEN + 4 + PHY_AW + REG_AW;
    localparam int FRAME_LEN = TA_POS + 2 + DATA_W;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX    = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] PRE_TA_IDX  = IDX_W'(TA_POS - 1);
    localparam logic [IDX_W-1:0] TA_IDX      = IDX_W'(TA_POS);

    typedef struct packed {
        logic                 busy;
        logic                 rd;
        logic [IDX_W-1:0]     idx;
        logic [FRAME_LEN-1:0] frame;
        logic                 oe;
        logic                 dout;
        logic                 done;
    } seq_t;

    seq_t seq_d, seq_q;

    assign accept = start && !seq_q.busy;
    assign finish = seq_q.busy && fall && (seq_q.idx == LAST_IDX);

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (accept) begin
            seq_d.busy  = 1'b1;
            seq_d.rd    = rd_req;
            seq_d.idx   = '0;
            seq_d.frame = {{PRE_LEN{1'b1}}, SOF_PAT,
                           rd_req ? OP_READ : OP_WRITE,
                           phy_addr, reg_addr,
                           rd_req ? 2'b00 : TA_DRIVE,
                           rd_req ? DATA_W'(0) : wr_data};
            seq_d.oe    = 1'b1;
            seq_d.dout  = seq_d.frame[FRAME_LEN-1];
        end else if (finish) begin
            seq_d.busy = 1'b0;
            seq_d.oe   = 1'b0;
            seq_d.dout = 1'b0;
            seq_d.done = 1'b1;
        end else if (seq_q.busy && fall) begin
            seq_d.idx   = seq_q.idx + 1'b1;
            seq_d.frame = {seq_q.frame[FRAME_LEN-2:0], 1'b0};
            seq_d.dout  = seq_d.frame[FRAME_LEN-1];
            seq_d.oe    = !seq_q.rd || (seq_q.idx < PRE_TA_IDX);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy    = seq_q.busy;
    assign rd_mode = seq_q.rd;
    assign bit_idx = seq_q.idx;
    assign mdio_o  = seq_q.dout;
    assign mdio_oe = seq_q.oe;
    assign done    = seq_q.done;

    // R6: a read never drives from turnaround onward
    a_r6_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.busy && seq_q.rd && (seq_q.idx >= TA_IDX) |-> !seq_q.oe);
    // R5: a write drives every bit
    a_r5_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.busy && !seq_q.rd |-> seq_q.oe);
    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |=> !seq_q.done);
    // R11: a frame in flight is untouched between falling edges
    a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.busy && !fall |=> seq_q.busy && $stable(seq_q.idx) && $stable(seq_q.frame));
    // R9: data output moves only on a falling clock edge while busy
    a_r9_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.busy && !fall |=> $stable(mdio_o));
endmodule

// File: rtl/mdio_rx.sv
module mdio_rx #(
    parameter int DATA_W  = 16,
    parameter int IDX_W   = 6,
    parameter int TA_LAST = 47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              finish,
    input  logic              rise,
    input  logic              rd_mode,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              mdio_i,
    output logic [DATA_W-1:0] rd_data,
    output logic              no_resp
);
    localparam logic [IDX_W-1:0] TA2_IDX = IDX_W'(TA_LAST);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic              ta_hi;
        logic [DATA_W-1:0] rdata;
        logic              nresp;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        if (accept) begin
            rx_d.nresp = 1'b0;
            rx_d.ta_hi = 1'b0;
        end
        if (rise && rd_mode) begin
            if (bit_idx == TA2_IDX)     rx_d.ta_hi = mdio_i;
            else if (bit_idx > TA2_IDX) rx_d.sh    = {rx_q.sh[DATA_W-2:0], mdio_i};
        end
        if (finish && rd_mode) begin
            rx_d.rdata = rx_q.sh;
            rx_d.nresp = rx_q.ta_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign rd_data = rx_q.rdata;
    assign no_resp = rx_q.nresp;

    // R8: the error flag only appears with the end of a read
    a_r8_flag_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_q.nresp) |-> $past(finish && rd_mode));
    // R7: read result is held between read completions
    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(finish && rd_mode) |=> $stable(rx_q.rdata));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int PRE_LEN  = 32,
    parameter int PHY_AW   = 5,
    parameter int REG_AW   = 5,
    parameter int DATA_W   = 16,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_req,
    input  logic [PHY_AW-1:0] phy_addr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mdio_i,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              no_resp
);
    localparam int TA_POS    = PRE_LEN + 4 + PHY_AW + REG_AW;
    localparam int FRAME_LEN = TA_POS + 2 + DATA_W;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    logic             rise, fall, accept, finish, rd_mode;
    logic [IDX_W-1:0] bit_idx;

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_gen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_seq #(
        .PRE_LEN(PRE_LEN), .PHY_AW(PHY_AW), .REG_AW(REG_AW), .DATA_W(DATA_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .rd_req  (rd_req),
        .phy_addr(phy_addr),
        .reg_addr(reg_addr),
        .wr_data (wr_data),
        .fall    (fall),
        .busy    (busy),
        .rd_mode (rd_mode),
        .bit_idx (bit_idx),
        .accept  (accept),
        .finish  (finish),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done    (done)
    );

    mdio_rx #(.DATA_W(DATA_W), .IDX_W(IDX_W), .TA_LAST(TA_POS + 1)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .finish (finish),
        .rise   (rise),
        .rd_mode(rd_mode),
        .bit_idx(bit_idx),
        .mdio_i (mdio_i),
        .rd_data(rd_data),
        .no_resp(no_resp)
    );

    // R1: idle after reset
    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> !busy && !done && !mdio_oe && !mdc);
    // R10: the line is released when done pulses
    a_r10_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mdio_oe && !busy);
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start, rd_req, mdio_i;
    logic [4:0]  phy_addr, reg_addr;
    logic [15:0] wr_data;
    logic        mdc, mdio_o, mdio_oe, busy, done, no_resp;
    logic [15:0] rd_data;

    int n_vec = 0;
    int n_bad = 0;
    logic [63:0] obs_o, obs_oe;
    realtime t_r1, t_r2, t_f1;

    always #10 clk = ~clk;

    mdio_master uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .busy(busy), .done(done), .rd_data(rd_data), .no_resp(no_resp)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic [15:0] phy_data,
                             input bit ta_bad, input bit poke);
        mdio_i = 1'b1;
        @(negedge clk);
        rd_req = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R10 busy after start", 64'(busy), 64'd1);
        for (int k = 0; k < 64; k++) begin
            @(posedge mdc); #1;
            obs_o[63-k]  = mdio_o;
            obs_oe[63-k] = mdio_oe;
            if (k == 1) t_r1 = $realtime;
            if (k == 2) t_r2 = $realtime;
            if (poke && k == 20) begin
                @(negedge clk);
                start = 1'b1; rd_req = ~rd; phy_addr = ~pa; wr_data = ~wd;
                @(negedge clk);
                start = 1'b0; rd_req = rd; phy_addr = pa; wr_data = wd;
            end
            @(negedge mdc); #1;
            if (k == 1) t_f1 = $realtime;
            if (rd && (k + 1) == 47)      mdio_i = ta_bad;
            else if (rd && (k + 1) >= 48 && (k + 1) <= 63) mdio_i = phy_data[63-(k+1)];
            else                          mdio_i = 1'b1;
        end
        chk(done === 1'b1, "R10 done at final falling edge", 64'(done), 64'd1);
        chk(busy === 1'b0 && mdio_oe === 1'b0, "R10 busy and drive released",
            {62'd0, busy, mdio_oe}, 64'd0);
        @(posedge clk); #1;
        chk(done === 1'b0, "R10 done lasts one cycle", 64'(done), 64'd0);
        mdio_i = 1'b1;
    endtask

    task automatic chk_header(input bit rd, input logic [4:0] pa, input logic [4:0] ra);
        chk(obs_o[63:32] === 32'hFFFF_FFFF, "R3 preamble ones", 64'(obs_o[63:32]), 64'hFFFF_FFFF);
        chk(obs_o[31:30] === 2'b01, "R3 start pattern", 64'(obs_o[31:30]), 64'd1);
        chk(obs_o[29:28] === (rd ? 2'b10 : 2'b01), "R4 opcode", 64'(obs_o[29:28]),
            64'(rd ? 2'b10 : 2'b01));
        chk(obs_o[27:18] === {pa, ra}, "R4 addresses msb first", 64'(obs_o[27:18]), 64'({pa, ra}));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start = 1'b0; rd_req = 1'b0; mdio_i = 1'b1;
        phy_addr = '0; reg_addr = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        #1;
        chk({mdc, mdio_oe, busy, done} === 4'b0, "R1 reset state", 64'({mdc, mdio_oe, busy, done}), 64'd0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk({mdc, mdio_oe, busy, done} === 4'b0, "R1 idle after release",
            64'({mdc, mdio_oe, busy, done}), 64'd0);
    endtask

    task automatic t_write();
        run_frame(1'b0, 5'h13, 5'h0A, 16'hBEEF, 16'h0, 1'b0, 1'b0);
        chk_header(1'b0, 5'h13, 5'h0A);
        chk(obs_o[17:0] === {2'b10, 16'hBEEF}, "R5 turnaround and data",
            64'(obs_o[17:0]), 64'({2'b10, 16'hBEEF}));
        chk(obs_oe === 64'hFFFF_FFFF_FFFF_FFFF, "R5 drive whole write", obs_oe, 64'hFFFF_FFFF_FFFF_FFFF);
        chk((t_r2 - t_r1) == 160.0, "R2 mdc period", 64'(int'(t_r2 - t_r1)), 64'd160);
        chk((t_f1 - t_r1) == 80.0, "R2 mdc high time", 64'(int'(t_f1 - t_r1)), 64'd80);
    endtask

    task automatic t_read(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] pd,
                          input bit ta_bad);
        run_frame(1'b1, pa, ra, 16'h0, pd, ta_bad, 1'b0);
        chk_header(1'b1, pa, ra);
        chk(obs_oe === {46'h3FFF_FFFF_FFFF, 18'h0}, "R6 release from turnaround",
            obs_oe, {46'h3FFF_FFFF_FFFF, 18'h0});
        chk(rd_data === pd, "R7 read data", 64'(rd_data), 64'(pd));
        chk(no_resp === ta_bad, "R8 no response flag", 64'(no_resp), 64'(ta_bad));
    endtask

    task automatic t_ignore();
        run_frame(1'b0, 5'h05, 5'h11, 16'h1234, 16'h0, 1'b0, 1'b1);
        chk_header(1'b0, 5'h05, 5'h11);
        chk(obs_o[15:0] === 16'h1234, "R11 mid-frame start ignored", 64'(obs_o[15:0]), 64'h1234);
        repeat (40) @(posedge clk);
        #1;
        chk(busy === 1'b0 && mdc === 1'b0, "R11 no queued transaction, R2 idle clock",
            {62'd0, busy, mdc}, 64'd0);
    endtask

    initial begin
        #(200000 * 20);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_write();
        t_read(5'h01, 5'h1F, 16'hA5C3, 1'b1);
        chk(rd_data === 16'hA5C3, "R7 data held after read", 64'(rd_data), 64'hA5C3);
        t_read(5'h00, 5'h02, 16'h8001, 1'b0);
        t_read(5'h1F, 5'h00, 16'hFFFF, 1'b0);
        t_ignore();
        chk(rd_data === 16'hFFFF, "R7 write leaves read data", 64'(rd_data), 64'hFFFF);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule